// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block is a first-in first-out buffer of 36-bit words that sits between two unrelated clock domains. A producer pushes words on its own write clock, and a consumer pulls them on an independent read clock. Both sides may be active on the same cycle. Storage is a simple dual-port array that can map onto block RAM. The write and read positions cross between the domains as Gray code through two-flop synchronisers, so each status flag asserts at once on its own side and clears a few cycles late.

At master reset a strap input picks one of two read-timing styles. In standard timing a read request moves the next word onto the data output one read clock later. The read-side flag reports empty and the write-side flag reports full. In fall-through timing the oldest word is presented on the output with no request. The read-side flag then means "output holds a valid word", the write-side flag means "room available", and a read request consumes the presented word. A half-full status is reported on the write side.

Two reset levels exist. Master reset empties the buffer and loads the timing style. Partial reset empties the buffer and keeps the loaded style. A retransmit pulse on the read side rewinds reading to the first word stored since the last reset. No idle cycles are needed before the replayed data is available.

Top module: `dcf_fifo`

## Requirements
- R1: After master reset with `fwft_sel_i`=0, `rd_flag_o`=1 (empty), `wr_flag_o`=0 (not full) and `half_o`=0. After master reset with `fwft_sel_i`=1, `rd_flag_o`=0 (no valid word) and `wr_flag_o`=1 (room available).
- R2: In standard timing, words come out in write order. A word appears on `rdata_o` after the read clock edge that samples `ren_i`=1 while `rd_flag_o`=0.
- R3: In standard timing, `wr_flag_o` rises after DEPTH words are stored and none is read. A write attempted while full is dropped and does not disturb the stored words.
- R4: `half_o` is 1 when the stored count seen by the write side is greater than DEPTH/2, and 0 when that count is DEPTH/2 or less.
- R5: In standard timing, `rd_flag_o` is 1 once every stored word has been read. A read request made while empty changes nothing: a word written afterwards is the next one returned.
- R6: In fall-through timing, the oldest word appears on `rdata_o` with `rd_flag_o`=1 and no read request. The presented word stays stable while `ren_i`=0. Each `ren_i` pulse presents the next word, and `rd_flag_o` falls after the last word is consumed.
- R7: `fwft_sel_i` (0 = standard, 1 = fall-through) is sampled only while `mrst_i` is high. Changing it later, or applying partial reset, leaves the timing style unchanged.
- R8: Partial reset empties the buffer. The flags return to their empty-state values for the timing style already loaded.
- R9: A one-cycle `rt_i` pulse, given while no write is in progress, restarts reading at the first word stored since reset. In standard timing the next read returns that word. In fall-through timing that word is on `rdata_o` with `rd_flag_o`=1 at the next read clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| mrst_i | input | 1 | Master reset, synchronous, active high, held for several cycles of both clocks |
| prst_i | input | 1 | Partial reset, synchronous, active high, keeps timing style |
| fwft_sel_i | input | 1 | Timing style strap, loaded during master reset |
| wen_i | input | 1 | Write request (write clock domain) |
| wdata_i | input | WIDTH | Write data |
| wr_flag_o | output | 1 | Full (standard) or room available (fall-through) |
| half_o | output | 1 | More than half the depth is occupied |
| ren_i | input | 1 | Read request (read clock domain) |
| rt_i | input | 1 | Retransmit pulse (read clock domain) |
| rdata_o | output | WIDTH | Read data, registered |
| rd_flag_o | output | 1 | Empty (standard) or output valid (fall-through) |

## Verification
On every cycle, the assertions check the following. A full buffer never advances the write position, and an empty standard-mode buffer never advances the read position. The write position's Gray code changes by at most one bit per write clock. Full always implies half-full. The timing style only changes under master reset. A presented fall-through word stays put until it is consumed. A retransmit pulse returns the read position to the origin. Only the directed scenarios can show data order through the clock crossing, the exact half-full threshold, that dropped writes and empty reads leave the contents intact, that partial reset keeps the timing style, and that replayed data matches the first words written.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    TIMING_STD  = 1'b0,
    TIMING_FWFT = 1'b1
  } timing_e;
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int WIDTH = 36,
  parameter int AW    = 10
) (
  input  logic             wclk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rclk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int AW = 10,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          wen,
  input  logic [PW-1:0] rgray_s,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [PW-1:0] wgray_o,
  output logic          wr_flag_o,
  output logic          half_o
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  logic          rst;
  timing_e       mode_q;
  logic [PW-1:0] wbin_q, wgray_q, wbin_nx, wgray_nx, rbin_s, used_nx;
  logic          full_q, half_q, push, full_nx, half_nx;

  assign rst = mrst | prst;

  always_comb begin
    push     = wen && !full_q;
    wbin_nx  = wbin_q + PW'(push);
    wgray_nx = wbin_nx ^ (wbin_nx >> 1);
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
    used_nx  = wbin_nx - rbin_s;
    full_nx  = (wgray_nx == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    half_nx  = (used_nx > PW'(HALF));
  end

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= timing_e'(fwft_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_nx;
      wgray_q <= wgray_nx;
      full_q  <= full_nx;
      half_q  <= half_nx;
    end
  end

  assign mem_we    = push;
  assign mem_waddr = wbin_q[AW-1:0];
  assign wgray_o   = wgray_q;
  assign half_o    = half_q;
  assign wr_flag_o = (mode_q == TIMING_FWFT) ? ~full_q : full_q;

  // R3: a write request against a full buffer leaves the write position alone
  a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    (full_q && wen) |=> (wbin_q == $past(wbin_q)));

  // R3: the crossing code moves by at most one bit per write clock
  a_r3_gray_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($countones(wgray_q ^ $past(wgray_q)) <= 1));

  // R4: a full buffer is always above the half mark
  a_r4_full_implies_half: assert property (@(posedge clk) disable iff (rst)
    full_q |-> half_q);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int AW = 10,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          fwft_sel,
  input  logic          ren,
  input  logic          rt,
  input  logic [PW-1:0] wgray_s,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [PW-1:0] rgray_o,
  output logic          rd_flag_o,
  output timing_e       mode_o
);
  logic          rst;
  timing_e       mode_q;
  logic [PW-1:0] rbin_q, rgray_q, base, rbin_nx, rgray_nx;
  logic          empty_q, ovalid_q, fire, empty_nx, ovalid_nx;

  assign rst = mrst | prst;

  always_comb begin
    base = rt ? '0 : rbin_q;
    if (mode_q == TIMING_FWFT) begin
      fire      = rt ? (wgray_s != '0) : ((!ovalid_q || ren) && !empty_q);
      ovalid_nx = fire ? 1'b1 : ((ren || rt) ? 1'b0 : ovalid_q);
    end else begin
      fire      = !rt && ren && !empty_q;
      ovalid_nx = 1'b0;
    end
    rbin_nx  = base + PW'(fire);
    rgray_nx = rbin_nx ^ (rbin_nx >> 1);
    empty_nx = (rgray_nx == wgray_s);
  end

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= timing_e'(fwft_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b1;
      ovalid_q <= 1'b0;
    end else begin
      rbin_q   <= rbin_nx;
      rgray_q  <= rgray_nx;
      empty_q  <= empty_nx;
      ovalid_q <= ovalid_nx;
    end
  end

  assign mem_re    = fire;
  assign mem_raddr = base[AW-1:0];
  assign rgray_o   = rgray_q;
  assign mode_o    = mode_q;
  assign rd_flag_o = (mode_q == TIMING_FWFT) ? ovalid_q : empty_q;

  // R5: no read position movement while empty in standard timing
  a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    (mode_q == TIMING_STD && empty_q && !rt) |=> (rbin_q == $past(rbin_q)));

  // R7: timing style is only reloaded by master reset
  a_r7_mode_hold: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> $stable(mode_q));

  // R9: retransmit lands the read position on the origin or one past it
  a_r9_rewind: assert property (@(posedge clk) disable iff (rst)
    rt |=> (rbin_q == '0 || rbin_q == PW'(1)));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
  import dcf_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int DEPTH = 1024
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             mrst_i,
  input  logic             prst_i,
  input  logic             fwft_sel_i,
  input  logic             wen_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             wr_flag_o,
  output logic             half_o,
  input  logic             ren_i,
  input  logic             rt_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             rd_flag_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          rst;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
  timing_e       rd_mode;

  assign rst = mrst_i | prst_i;

  dcf_sync2 #(.W(PW)) u_w2r (
    .clk(rclk_i), .rst(rst), .d(wgray), .q(wgray_s)
  );

  dcf_sync2 #(.W(PW)) u_r2w (
    .clk(wclk_i), .rst(rst), .d(rgray), .q(rgray_s)
  );

  dcf_wr_side #(.AW(AW)) u_wr (
    .clk(wclk_i), .mrst(mrst_i), .prst(prst_i), .fwft_sel(fwft_sel_i),
    .wen(wen_i), .rgray_s(rgray_s), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .wgray_o(wgray), .wr_flag_o(wr_flag_o), .half_o(half_o)
  );

  dcf_rd_side #(.AW(AW)) u_rd (
    .clk(rclk_i), .mrst(mrst_i), .prst(prst_i), .fwft_sel(fwft_sel_i),
    .ren(ren_i), .rt(rt_i), .wgray_s(wgray_s), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .rgray_o(rgray), .rd_flag_o(rd_flag_o),
    .mode_o(rd_mode)
  );

  dcf_ram #(.WIDTH(WIDTH), .AW(AW)) u_ram (
    .wclk(wclk_i), .we(mem_we), .waddr(mem_waddr), .wdata(wdata_i),
    .rclk(rclk_i), .re(mem_re), .raddr(mem_raddr), .rdata(rdata_o)
  );

  // R6: a presented fall-through word holds until consumed or rewound
  a_r6_fwft_hold: assert property (@(posedge rclk_i) disable iff (rst)
    (rd_mode == TIMING_FWFT && rd_flag_o && !ren_i && !rt_i)
      |=> (rd_flag_o && $stable(rdata_o)));
endmodule

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/100ps
module dcf_fifo_tb_top;
  localparam int W = 36;
  localparam int D = 16;

  logic         wclk = 0, rclk = 0;
  logic         mrst = 1, prst = 0, fwft_sel = 0;
  logic         wen = 0, ren = 0, rt = 0;
  logic [W-1:0] wdata = '0;
  logic         wr_flag, half, rd_flag;
  logic [W-1:0] rdata;
  int           tests = 0, fails = 0;

  always #4.0 wclk = ~wclk;
  always #5.5 rclk = ~rclk;

  dcf_fifo #(.WIDTH(W), .DEPTH(D)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .mrst_i(mrst), .prst_i(prst),
    .fwft_sel_i(fwft_sel), .wen_i(wen), .wdata_i(wdata),
    .wr_flag_o(wr_flag), .half_o(half), .ren_i(ren), .rt_i(rt),
    .rdata_o(rdata), .rd_flag_o(rd_flag)
  );

  function automatic logic [W-1:0] pat(input int base, input int i);
    return W'(36'h5_A000_0000) ^ W'(base * 4096 + i * 37 + 1);
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_w(input int n); repeat (n) @(negedge wclk); endtask
  task automatic wait_r(input int n); repeat (n) @(negedge rclk); endtask

  task automatic do_reset(input logic master, input logic sel);
    @(negedge wclk);
    fwft_sel = sel;
    mrst = master;
    prst = !master;
    wait_w(8);
    mrst = 0;
    prst = 0;
    wait_w(1);
    fwft_sel = !sel;
    wait_r(3);
  endtask

  task automatic push_n(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk);
      wen = 1;
      wdata = pat(base, i);
    end
    @(negedge wclk);
    wen = 0;
  endtask

  task automatic pop_std(input string req, input logic [W-1:0] exp);
    @(negedge rclk);
    ren = 1;
    @(negedge rclk);
    ren = 0;
    check(req, rdata, exp);
  endtask

  task automatic rt_pulse();
    @(negedge rclk);
    rt = 1;
    @(negedge rclk);
    rt = 0;
  endtask

  task automatic t_reset_std();
    do_reset(1, 0);
    check("R1 empty after reset", W'(rd_flag), W'(1));
    check("R1 full clear", W'(wr_flag), W'(0));
    check("R1 half clear", W'(half), W'(0));
  endtask

  task automatic t_std_basic();
    push_n(1, 5);
    wait_r(6);
    check("R2 empty low after writes", W'(rd_flag), W'(0));
    for (int i = 0; i < 5; i++) pop_std("R2 order", pat(1, i));
    check("R5 empty after drain", W'(rd_flag), W'(1));
    pop_std("R5 read while empty", rdata);
    pop_std("R5 read while empty", rdata);
    push_n(2, 1);
    wait_r(6);
    pop_std("R5 next word after ignored reads", pat(2, 0));
    check("R5 empty again", W'(rd_flag), W'(1));
  endtask

  task automatic t_full_half();
    push_n(3, 4);
    do_reset(0, 0);
    check("R8 partial reset empties", W'(rd_flag), W'(1));
    check("R8 half clear", W'(half), W'(0));
    push_n(4, D);
    check("R3 full after DEPTH writes", W'(wr_flag), W'(1));
    check("R4 half when full", W'(half), W'(1));
    push_n(99, 1);
    wait_r(6);
    for (int i = 0; i < 7; i++) pop_std("R3 data intact", pat(4, i));
    wait_w(6);
    check("R4 half at DEPTH/2+1", W'(half), W'(1));
    check("R3 full clears", W'(wr_flag), W'(0));
    pop_std("R3 data intact", pat(4, 7));
    wait_w(6);
    check("R4 half low at DEPTH/2", W'(half), W'(0));
    for (int i = 8; i < D; i++) pop_std("R3 dropped write absent", pat(4, i));
    check("R3 empty after DEPTH reads", W'(rd_flag), W'(1));
  endtask

  task automatic t_rt_std();
    do_reset(0, 0);
    push_n(5, 4);
    wait_r(6);
    pop_std("R2 before rewind", pat(5, 0));
    pop_std("R2 before rewind", pat(5, 1));
    rt_pulse();
    for (int i = 0; i < 4; i++) pop_std("R9 std replay", pat(5, i));
    check("R9 empty after replay", W'(rd_flag), W'(1));
  endtask

  task automatic t_fwft();
    do_reset(1, 1);
    check("R1 fwft output not valid", W'(rd_flag), W'(0));
    check("R1 fwft room available", W'(wr_flag), W'(1));
    push_n(6, 3);
    wait_r(8);
    check("R6 first word valid", W'(rd_flag), W'(1));
    check("R6 first word no read", rdata, pat(6, 0));
    wait_r(3);
    check("R6 word held", rdata, pat(6, 0));
    for (int i = 1; i < 3; i++) begin
      pop_std("R6 next word", pat(6, i));
      check("R6 still valid", W'(rd_flag), W'(1));
    end
    @(negedge rclk); ren = 1;
    @(negedge rclk); ren = 0;
    check("R6 valid drops after last", W'(rd_flag), W'(0));
    do_reset(0, 0);
    check("R7 partial keeps fwft flag", W'(rd_flag), W'(0));
    check("R7 partial keeps room flag", W'(wr_flag), W'(1));
    push_n(7, 1);
    wait_r(8);
    check("R7 fwft after partial", W'(rd_flag), W'(1));
    check("R8 fresh data after partial", rdata, pat(7, 0));
  endtask

  task automatic t_rt_fwft();
    do_reset(0, 1);
    push_n(8, 3);
    wait_r(8);
    check("R6 head", rdata, pat(8, 0));
    pop_std("R6 advance", pat(8, 1));
    rt_pulse();
    check("R9 fwft replay word", rdata, pat(8, 0));
    check("R9 fwft valid", W'(rd_flag), W'(1));
    pop_std("R9 fwft continues", pat(8, 1));
  endtask

  initial begin
    t_reset_std();
    t_std_basic();
    t_full_half();
    t_rt_std();
    t_fwft();
    t_rt_fwft();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wclk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule